// File: doc/BRIEF.md
# Local Interval Tick Timer

A register bank for one core's tick timer. Counting happens in two stages. A prescaler divides the input clock by the programmed base count plus one, and each prescaler tick steps an interrupt down-counter. When the down-counter reaches its end, the block raises a pending tick interrupt. In one-shot operation the counter then stops. In interval operation it reloads from the count buffer, so the ticks repeat until software clears the start bits.

Software reaches the bank through a 32-bit register bus with an 8-bit offset, so that banks can be placed 0x100 apart. Writes take effect on the clock edge that samples them, and reads return data combinationally. Each write to the base count, count buffer or control register leaves a write-applied flag in a status word, and software clears that flag by writing a 1 to it.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every register reads zero (base count 0x00, count buffer 0x08, control 0x20, interrupt status 0x30, interrupt enable 0x34, write-status 0x40), and `irq_o` is low.
- R2: While the run bit (control bit 0) is set, the prescaler produces one tick every base-count-plus-one clock edges.
- R3: A write to 0x08 always stores bits 30:0 in the buffer. Only when bit 31 of that write is set are those bits loaded into the active counter, and the prescaler phase restarts at the same edge. A write with bit 31 clear leaves the running countdown unchanged.
- R4: With interval mode (control bit 2) clear, the pending flag sets on the edge of the N-th tick after start, where N is the loaded count. The counter then stops and raises nothing further.
- R5: With interval mode set, the counter reloads from the buffer at each expiry, so the next interrupt follows after buffer-count ticks.
- R6: A count of zero behaves as a count of one.
- R7: Clearing the run bit freezes both the prescaler and the counter. Setting it again resumes from the frozen state.
- R8: The pending flag (status bit 0) sets on expiry only while the interrupt-start bit (control bit 1) is set.
- R9: Writing 1 to status bit 0 clears the pending flag. Writing 0 there leaves the flag unchanged, and an expiry in the same cycle takes priority over the clear.
- R10: `irq_o` is high exactly when the pending flag and enable bit 0 (at 0x34) are both set.
- R11: The write-status flags are bit 0 for a base-count write, bit 1 for a count-buffer write and bit 3 for a control write. Each flag sets on the edge of its write, and writing 1 to a bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write offset within the bank |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read offset within the bank |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | Tick interrupt request |

## Verification
Take Es as the edge that writes the run bit, B as the base count and N as the effective count. The pending flag is due exactly at edge Es + N·(B+1). The bench keeps an edge counter, checks the flag low one edge before that point and high at it, and samples on the falling edge. For a halted run, the bench subtracts the edges that elapsed before the stop from the target it expects after the restart. Write-status and register readback are checked on the falling edge right after the writing edge, because reads are combinational.

// File: rtl/tick_pkg.sv
package tick_pkg;
   localparam int BUS_W  = 32;
   localparam int ADDR_W = 8;
   localparam logic [ADDR_W-1:0] OFF_TBASE = 8'h00;
   localparam logic [ADDR_W-1:0] OFF_ICNT  = 8'h08;
   localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h20;
   localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h30;
   localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h34;
   localparam logic [ADDR_W-1:0] OFF_WSTAT = 8'h40;
   localparam int CTL_RUN  = 0;
   localparam int CTL_INTS = 1;
   localparam int CTL_RPT  = 2;
   localparam int UPD_BIT  = 31;
   localparam int WS_TBASE = 0;
   localparam int WS_ICNT  = 1;
   localparam int WS_CTRL  = 3;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
   parameter int PRE_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PRE_W-1:0] limit,
   output logic             tick
);
   logic [PRE_W-1:0] pre_q;

   assign tick = run && !restart && (pre_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pre_q <= '0;
      else if (restart)  pre_q <= '0;
      else if (run) begin
         if (pre_q == limit) pre_q <= '0;
         else                pre_q <= pre_q + 1'b1;
      end
   end

   // R7
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> $stable(pre_q));
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
   parameter int CNT_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             tick,
   input  logic             interval,
   output logic             expire
);
   logic [CNT_W-1:0] cur_q;

   function automatic logic [CNT_W-1:0] eff(input logic [CNT_W-1:0] v);
      return (v == '0) ? CNT_W'(1) : v;
   endfunction

   assign expire = tick && !load && (cur_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cur_q <= '0;
      else if (load)                  cur_q <= eff(load_val);
      else if (expire)                cur_q <= interval ? eff(reload_val) : '0;
      else if (tick && cur_q != '0)   cur_q <= cur_q - 1'b1;
   end

   // R4
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !interval) |=> (cur_q == '0));
   // R6
   zero_as_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cur_q != '0));
endmodule

// File: rtl/tick_regs.sv
module tick_regs
   import tick_pkg::*;
#(
   parameter int PRE_W = 32,
   parameter int CNT_W = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BUS_W-1:0]  rd_data,
   input  logic              expire,
   output logic [PRE_W-1:0]  tbase,
   output logic [CNT_W-1:0]  cnt_buf,
   output logic              run,
   output logic              interval,
   output logic              load,
   output logic              pend,
   output logic              ien
);
   logic [2:0] ctrl_q;
   logic [3:0] wstat_q;
   logic       wr_tb, wr_ic, wr_ct, wr_st, wr_ie, wr_ws;

   assign wr_tb = wr_en && (wr_addr == OFF_TBASE);
   assign wr_ic = wr_en && (wr_addr == OFF_ICNT);
   assign wr_ct = wr_en && (wr_addr == OFF_CTRL);
   assign wr_st = wr_en && (wr_addr == OFF_STAT);
   assign wr_ie = wr_en && (wr_addr == OFF_IEN);
   assign wr_ws = wr_en && (wr_addr == OFF_WSTAT);

   assign load     = wr_ic && wr_data[UPD_BIT];
   assign run      = ctrl_q[CTL_RUN];
   assign interval = ctrl_q[CTL_RPT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbase   <= '0;
         cnt_buf <= '0;
         ctrl_q  <= '0;
         ien     <= 1'b0;
         pend    <= 1'b0;
         wstat_q <= '0;
      end else begin
         if (wr_tb) tbase   <= wr_data[PRE_W-1:0];
         if (wr_ic) cnt_buf <= wr_data[CNT_W-1:0];
         if (wr_ct) ctrl_q  <= wr_data[2:0];
         if (wr_ie) ien     <= wr_data[0];
         if (expire && ctrl_q[CTL_INTS]) pend <= 1'b1;
         else if (wr_st && wr_data[0])   pend <= 1'b0;
         if (wr_ws) wstat_q <= wstat_q & ~wr_data[3:0];
         else begin
            if (wr_tb) wstat_q[WS_TBASE] <= 1'b1;
            if (wr_ic) wstat_q[WS_ICNT]  <= 1'b1;
            if (wr_ct) wstat_q[WS_CTRL]  <= 1'b1;
         end
      end
   end

   always_comb begin
      case (rd_addr)
         OFF_TBASE: rd_data = BUS_W'(tbase);
         OFF_ICNT:  rd_data = BUS_W'(cnt_buf);
         OFF_CTRL:  rd_data = BUS_W'(ctrl_q);
         OFF_STAT:  rd_data = BUS_W'(pend);
         OFF_IEN:   rd_data = BUS_W'(ien);
         OFF_WSTAT: rd_data = BUS_W'(wstat_q);
         default:   rd_data = '0;
      endcase
   end

   // R11
   wstat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_tb |=> wstat_q[WS_TBASE]);
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
   import tick_pkg::*;
#(
   parameter int PRE_W = 32,
   parameter int CNT_W = 31
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [7:0]  wr_addr,
   input  logic [31:0] wr_data,
   input  logic [7:0]  rd_addr,
   output logic [31:0] rd_data,
   output logic        irq_o
);
   if (CNT_W < 2 || CNT_W > UPD_BIT) begin : g_bad_cnt
      $error("CNT_W must lie in 2..31");
   end
   if (PRE_W < 1 || PRE_W > BUS_W) begin : g_bad_pre
      $error("PRE_W must lie in 1..32");
   end

   logic [PRE_W-1:0] tbase;
   logic [CNT_W-1:0] cnt_buf;
   logic             run, interval, load, pend, ien, tick, expire;

   tick_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .expire(expire), .tbase(tbase), .cnt_buf(cnt_buf), .run(run),
      .interval(interval), .load(load), .pend(pend), .ien(ien));

   tick_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(load),
      .limit(tbase), .tick(tick));

   tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load),
      .load_val(wr_data[CNT_W-1:0]), .reload_val(cnt_buf),
      .tick(tick), .interval(interval), .expire(expire));

   assign irq_o = pend & ien;

   // R8
   pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(expire));
endmodule

// File: tb/sim_tick_timer_bank.sv
module sim_tick_timer_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq_o;
   int          checks = 0;
   int          errors = 0;
   int unsigned cyc = 0;
   bit          done = 1'b0;

   tick_timer_bank u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o));

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int unsigned period(input int unsigned tb, input int unsigned n);
      return ((n == 0) ? 1 : n) * (tb + 1);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      check(req, rd_data, exp);
   endtask

   task automatic wait_to(input int unsigned t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      int unsigned c, c1, c2, c3, t, e;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rdchk("R1 tbase", 8'h00, 0);
      rdchk("R1 icnt", 8'h08, 0);
      rdchk("R1 ctrl", 8'h20, 0);
      rdchk("R1 stat", 8'h30, 0);
      rdchk("R1 ien", 8'h34, 0);
      rdchk("R1 wstat", 8'h40, 0);
      check("R1 irq", irq_o, 0);

      // R11 write-status flags
      wr(8'h00, 32'd2);
      rdchk("R11 wstat tbase", 8'h40, 32'h1);
      wr(8'h08, 32'h8000_0004);
      rdchk("R11 wstat icnt", 8'h40, 32'h3);
      rdchk("R3 buffer readback", 8'h08, 32'h4);
      wr(8'h20, 32'h0);
      rdchk("R11 wstat ctrl", 8'h40, 32'hB);
      wr(8'h40, 32'h2);
      rdchk("R11 w1c partial", 8'h40, 32'h9);
      wr(8'h40, 32'hB);
      rdchk("R11 w1c all", 8'h40, 32'h0);

      // R2 R4 R6 random one-shot runs
      wr(8'h34, 32'h1);
      for (int i = 0; i < 10; i++) begin
         int unsigned tb, n;
         tb = $urandom % 4;
         n  = (i == 0) ? 0 : $urandom % 6;
         t  = period(tb, n);
         wr(8'h00, tb);
         wr(8'h08, 32'h8000_0000 | n);
         wr(8'h20, 32'h3);
         c = cyc;
         wait_to(c + t - 1);
         rdchk((n == 0) ? "R6 early" : "R2 early", 8'h30, 0);
         wait_to(c + t);
         rdchk((n == 0) ? "R6 due" : "R4 due", 8'h30, 1);
         check("R10 irq on", irq_o, 1);
         wr(8'h30, 32'h1);
         rdchk("R9 cleared", 8'h30, 0);
         wait_to(c + 2 * t + 4);
         rdchk("R4 stopped", 8'h30, 0);
         wr(8'h20, 32'h0);
      end

      // R3 R5 buffer write without flag, interval reload
      wr(8'h00, 32'd1);
      wr(8'h08, 32'h8000_0003);
      wr(8'h08, 32'h0000_0005);
      wr(8'h20, 32'h7);
      c = cyc;
      wait_to(c + 5);
      rdchk("R3 early", 8'h30, 0);
      wait_to(c + 6);
      rdchk("R3 active count kept", 8'h30, 1);
      wr(8'h30, 32'h1);
      wait_to(c + 15);
      rdchk("R5 early", 8'h30, 0);
      wait_to(c + 16);
      rdchk("R5 reload", 8'h30, 1);
      wr(8'h30, 32'h1);
      wait_to(c + 25);
      rdchk("R5 early2", 8'h30, 0);
      wait_to(c + 26);
      rdchk("R5 repeat", 8'h30, 1);
      wr(8'h20, 32'h0);
      wr(8'h30, 32'h1);

      // R8 interrupt start off
      wr(8'h00, 32'd0);
      wr(8'h08, 32'h8000_0002);
      wr(8'h20, 32'h1);
      c = cyc;
      wait_to(c + 10);
      rdchk("R8 no pend", 8'h30, 0);
      check("R8 no irq", irq_o, 0);
      wr(8'h20, 32'h0);

      // R10 enable gate, R9 write zero ignored
      wr(8'h34, 32'h0);
      wr(8'h08, 32'h8000_0002);
      wr(8'h20, 32'h3);
      c = cyc;
      wait_to(c + 3);
      rdchk("R10 pend set", 8'h30, 1);
      check("R10 irq gated", irq_o, 0);
      wr(8'h30, 32'h0);
      rdchk("R9 zero ignored", 8'h30, 1);
      wr(8'h34, 32'h1);
      #1 check("R10 irq enabled", irq_o, 1);
      wr(8'h30, 32'h1);
      rdchk("R9 w1c", 8'h30, 0);
      check("R10 irq off", irq_o, 0);
      wr(8'h20, 32'h0);

      // R7 halt and resume
      wr(8'h00, 32'd3);
      wr(8'h08, 32'h8000_0005);
      t = period(3, 5);
      wr(8'h20, 32'h3);
      c1 = cyc;
      wr(8'h20, 32'h2);
      c2 = cyc;
      wait_to(c2 + 40);
      rdchk("R7 halted", 8'h30, 0);
      wr(8'h20, 32'h3);
      c3 = cyc;
      e = c3 + t - (c2 - c1);
      wait_to(e - 1);
      rdchk("R7 resume early", 8'h30, 0);
      wait_to(e);
      rdchk("R7 resume due", 8'h30, 1);

      finish_run();
   end
endmodule